// File: doc/BRIEF.md
# Vertical and Horizontal Sync Conditioner

This block sits in the pixel clock domain between a raw sync source and the rest of a video path. It turns raw, active-high horizontal and vertical sync inputs into cleaned-up sync outputs. The horizontal output is rebuilt as a pulse whose width is a programmed number of pixel clocks. Each rising edge of the raw horizontal input starts that pulse.

When filtering is on, a vertical sync edge is held until the next horizontal edge. Only then is it acted on, so the vertical output always starts after the horizontal output. A vertical edge is accepted only when enough lines have passed since the previous accepted one. Edges that come too early are dropped as noise.

The vertical output width can follow the raw input, or it can be set to a programmed number of lines. Each output has its own polarity select. All configuration arrives on static inputs, and the owner of those settings is expected to hold them steady while pulses are in flight.

Top module: `sync_conditioner`

## Requirements
- R1: A rising edge on `hs_in` (active high) makes the horizontal output active from the next clock. It stays active for max(`hs_len`,1) clocks, so a length of 0 gives a one-clock pulse.
- R2: With `flt_en`=1, a vertical rising edge is held until the first `hs_in` rising edge seen in the same clock or later. If accepted, the vertical output goes active exactly one clock after the horizontal output goes active.
- R3: With `flt_en`=1, a held vertical edge is accepted only if the horizontal edge it waits for is at least MIN_LINES horizontal edges after the horizontal edge of the previous acceptance. Otherwise it is dropped with no output pulse, and the line spacing count carries on unchanged.
- R4: The line spacing count saturates instead of wrapping. The first vertical edge after reset is always accepted, and so is any edge after a gap longer than the counter range.
- R5: With `flt_en`=0, every rising edge of `vs_in` is accepted with no spacing rule. The vertical output goes active two clocks after the input edge is presented.
- R6: With `dur_en`=1, the vertical output ends on the clock that registers the N-th horizontal rising edge after acceptance, where N = max(`vs_len`,1).
- R7: With `dur_en`=0, the vertical output, once started, ends two clocks after `vs_in` falls.
- R8: `hs_pol` and `vs_pol` each select the active level of their own output: 1 means active high and 0 means active low. While `rst_n` is low, both outputs sit at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_in | input | 1 | Raw horizontal sync, active high |
| vs_in | input | 1 | Raw vertical sync, active high |
| flt_en | input | 1 | 1 = vertical filter on, 0 = bypass |
| dur_en | input | 1 | 1 = vertical width from `vs_len`, 0 = follow input |
| vs_len | input | DUR_W | Vertical width in lines |
| hs_len | input | DUR_W | Horizontal width in clocks |
| hs_pol | input | 1 | Horizontal output polarity, 1 = active high |
| vs_pol | input | 1 | Vertical output polarity, 1 = active high |
| hs_out | output | 1 | Conditioned horizontal sync |
| vs_out | output | 1 | Conditioned vertical sync |

## Verification
The bench builds the block with MIN_LINES set to 4 and DUR_W left at 8, using twelve-clock lines. A spacing of 4 makes the reject and accept edge of the spacing rule only a few lines apart. It also makes the three-bit line counter reach its limit well inside a 17-line gap, where a wrapping counter would reject. Keeping DUR_W at 8 lets the horizontal width run over the full 0 to 255 range, including the zero-as-one case and the maximum.

// File: rtl/sc_pkg.sv
package sc_pkg;

  // A programmed length of zero still yields a one-unit pulse.
  function automatic int unsigned eff_len(int unsigned len);
    return (len == 0) ? 1 : len;
  endfunction

  // Count up by one, holding at the limit.
  function automatic int unsigned sat_step(int unsigned v, int unsigned lim);
    return (v >= lim) ? v : v + 1;
  endfunction

endpackage

// File: rtl/sc_edge_det.sv
module sc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic lvl
);
  always_ff @(posedge clk) begin
    if (!rst_n) lvl <= 1'b0;
    else        lvl <= din;
  end

  assign rise = din & ~lvl;
endmodule

// File: rtl/sc_pulse_len.sv
module sc_pulse_len #(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic [DUR_W-1:0] len,
  output logic             act
);
  logic [DUR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (start)              cnt <= DUR_W'(sc_pkg::eff_len(32'(len)));
    else if (step && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign act = (cnt != '0);
endmodule

// File: rtl/sc_vs_filter.sv
module sc_vs_filter #(
  parameter int MIN_LINES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flt_en,
  input  logic hs_rise,
  input  logic vs_rise,
  output logic take
);
  localparam int LW = $clog2(MIN_LINES + 1);

  logic [LW-1:0] lines, lines_nx;
  logic          pend, wanted, take_flt;

  assign lines_nx = LW'(sc_pkg::sat_step(32'(lines), MIN_LINES));
  assign wanted   = pend | vs_rise;
  assign take_flt = hs_rise & wanted & (lines_nx >= LW'(MIN_LINES));
  assign take     = flt_en ? take_flt : vs_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lines <= LW'(MIN_LINES);
      pend  <= 1'b0;
    end else begin
      if (hs_rise) lines <= take_flt ? '0 : lines_nx;
      if (!flt_en || hs_rise) pend <= 1'b0;
      else if (vs_rise)       pend <= 1'b1;
    end
  end
endmodule

// File: rtl/sc_vs_width.sv
module sc_vs_width #(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             line_tick,
  input  logic             src_lvl,
  input  logic             dur_en,
  input  logic [DUR_W-1:0] len,
  output logic             act
);
  logic cnt_act, fol_act;

  sc_pulse_len #(.DUR_W(DUR_W)) u_lines (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .step  (line_tick),
    .len   (len),
    .act   (cnt_act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        fol_act <= 1'b0;
    else if (start)    fol_act <= 1'b1;
    else if (!src_lvl) fol_act <= 1'b0;
  end

  assign act = dur_en ? cnt_act : fol_act;
endmodule

// File: rtl/sync_conditioner.sv
module sync_conditioner #(
  parameter int DUR_W     = 8,
  parameter int MIN_LINES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             flt_en,
  input  logic             dur_en,
  input  logic [DUR_W-1:0] vs_len,
  input  logic [DUR_W-1:0] hs_len,
  input  logic             hs_pol,
  input  logic             vs_pol,
  output logic             hs_out,
  output logic             vs_out
);
  logic hs_rise, hs_lvl, vs_rise, vs_lvl;
  logic vs_take, vs_take_q, hs_act, vs_act;

  sc_edge_det u_hs_edge (.clk(clk), .rst_n(rst_n), .din(hs_in), .rise(hs_rise), .lvl(hs_lvl));
  sc_edge_det u_vs_edge (.clk(clk), .rst_n(rst_n), .din(vs_in), .rise(vs_rise), .lvl(vs_lvl));

  sc_pulse_len #(.DUR_W(DUR_W)) u_hs_len (
    .clk   (clk),
    .rst_n (rst_n),
    .start (hs_rise),
    .step  (1'b1),
    .len   (hs_len),
    .act   (hs_act)
  );

  sc_vs_filter #(.MIN_LINES(MIN_LINES)) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .flt_en  (flt_en),
    .hs_rise (hs_rise),
    .vs_rise (vs_rise),
    .take    (vs_take)
  );

  // One register between acceptance and the vertical pulse keeps the
  // vertical output one clock behind the horizontal one.
  always_ff @(posedge clk) begin
    if (!rst_n) vs_take_q <= 1'b0;
    else        vs_take_q <= vs_take;
  end

  sc_vs_width #(.DUR_W(DUR_W)) u_vs_width (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (vs_take_q),
    .line_tick (hs_rise),
    .src_lvl   (vs_lvl),
    .dur_en    (dur_en),
    .len       (vs_len),
    .act       (vs_act)
  );

  assign hs_out = hs_pol ? hs_act : ~hs_act;
  assign vs_out = vs_pol ? vs_act : ~vs_act;
endmodule

// File: rtl/sc_sync_chk.sv
module sc_sync_chk #(
  parameter int MIN_LINES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic flt_en,
  input logic hs_rise,
  input logic hs_lvl,
  input logic vs_rise,
  input logic vs_take_q,
  input logic hs_act,
  input logic vs_act
);
  localparam int GW = $clog2(MIN_LINES + 1);

  // Independent count of horizontal edges since the last filtered acceptance.
  logic [GW-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n)                 gap <= GW'(MIN_LINES);
    else if (vs_take_q && flt_en) gap <= '0;
    else if (hs_rise && gap < GW'(MIN_LINES)) gap <= gap + 1'b1;
  end

  a_r1_hs_starts_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_act) |-> ($past(hs_rise) && hs_lvl));

  a_r2_vs_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && $past(flt_en) && vs_take_q) |-> $past(hs_rise));

  a_r3_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && $past(flt_en) && vs_take_q) |-> (gap >= GW'(MIN_LINES)));

  a_r5_bypass_takes_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_en && vs_rise) |=> vs_take_q);

  a_r6_take_starts_vs: assert property (@(posedge clk) disable iff (!rst_n)
    vs_take_q |=> vs_act);
endmodule

bind sync_conditioner sc_sync_chk #(.MIN_LINES(MIN_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flt_en    (flt_en),
  .hs_rise   (hs_rise),
  .hs_lvl    (hs_lvl),
  .vs_rise   (vs_rise),
  .vs_take_q (vs_take_q),
  .hs_act    (hs_act),
  .vs_act    (vs_act)
);

// File: tb/tb_sync_conditioner.sv
module tb_sync_conditioner;
  localparam int CLK_PERIOD = 10;
  localparam int LINE = 12;
  localparam int MINL = 4;

  typedef struct packed {
    logic [7:0] dur;
    logic       pol;
    int         exp;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{8'd32, 1'b1, 32}, '{8'd0, 1'b1, 1}, '{8'd1, 1'b0, 1},
    '{8'd5, 1'b0, 5}, '{8'd255, 1'b1, 255}, '{8'd2, 1'b1, 2}};

  logic clk = 1'b0, rst_n = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
  logic flt_en = 1'b0, dur_en = 1'b0, hs_pol = 1'b1, vs_pol = 1'b1;
  logic [7:0] vs_len = 8'd1, hs_len = 8'd4;
  logic hs_out, vs_out;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int hs_cnt = 0, vs_n = 0, hs_first = 0, vs_first = 0, vs_fall = 0;
  int hs_drv = 0, vs_set = 0, vs_clr = 0;
  logic ha, va, hs_p = 1'b0, vs_p = 1'b0;
  bit done = 1'b0;

  sync_conditioner #(.DUR_W(8), .MIN_LINES(MINL)) dut (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in),
    .flt_en(flt_en), .dur_en(dur_en), .vs_len(vs_len), .hs_len(hs_len),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .hs_out(hs_out), .vs_out(vs_out));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      ha = (hs_out == hs_pol);
      va = (vs_out == vs_pol);
      if (ha) hs_cnt = hs_cnt + 1;
      if (ha && !hs_p) hs_first = cyc;
      if (va && !vs_p) begin vs_first = cyc; vs_n = vs_n + 1; end
      if (!va && vs_p) vs_fall = cyc;
      hs_p = ha;
      vs_p = va;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_line(input int set_at, input int clr_at);
    for (int i = 0; i < LINE; i++) begin
      @(negedge clk);
      if (i == 0) begin hs_in = 1'b1; hs_drv = cyc; end
      if (i == 3) hs_in = 1'b0;
      if (i == set_at) begin vs_in = 1'b1; vs_set = cyc; end
      if (i == clr_at) begin vs_in = 1'b0; vs_clr = cyc; end
    end
  endtask

  task automatic plain(input int n);
    for (int k = 0; k < n; k++) run_line(-1, -1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n0, c0, cA, cnt0;

    // R8: inactive levels while reset is held, for both polarities
    tick(3);
    chk("R8 reset hs idle high-pol", int'(hs_out), 0);
    chk("R8 reset vs idle high-pol", int'(vs_out), 0);
    @(posedge clk); hs_pol = 1'b0; vs_pol = 1'b0;
    tick(1);
    chk("R8 reset hs idle low-pol", int'(hs_out), 1);
    chk("R8 reset vs idle low-pol", int'(vs_out), 1);
    @(posedge clk); hs_pol = 1'b1; vs_pol = 1'b1;
    tick(1);
    rst_n = 1'b1;
    tick(2);

    // R1: table of horizontal widths and polarities
    for (int v = 0; v < 6; v++) begin
      @(posedge clk); hs_pol = VECS[v].pol; hs_len = VECS[v].dur;
      tick(2);
      cnt0 = hs_cnt;
      run_line(-1, -1);
      tick(300);
      chk("R1 hs width", hs_cnt - cnt0, VECS[v].exp);
      chk("R1 hs start", hs_first, hs_drv + 1);
    end
    @(posedge clk); hs_pol = 1'b1; hs_len = 8'd4;

    // R2/R3/R6: filter on, one-line vertical width
    tick(1);
    flt_en = 1'b1; dur_en = 1'b1; vs_len = 8'd1;
    plain(2);
    n0 = vs_n;
    run_line(5, -1);
    run_line(-1, 8); cA = hs_drv;
    chk("R4 first after reset accepted", vs_n - n0, 1);
    chk("R2 vs follows hs by one", vs_first, cA + 2);
    plain(1);
    chk("R6 one-line width", vs_fall - vs_first, LINE - 1);
    n0 = vs_n;
    run_line(5, 8);
    run_line(5, 8);
    chk("R3 early edge dropped", vs_n - n0, 0);
    run_line(-1, -1); c0 = hs_drv;
    chk("R3 boundary edge accepted", vs_n - n0, 1);
    chk("R3 boundary timing", vs_first, c0 + 2);

    // R4: long gap past the counter range
    plain(15);
    n0 = vs_n;
    run_line(5, 8);
    run_line(-1, -1); c0 = hs_drv;
    chk("R4 saturated count accepts", vs_n - n0, 1);
    chk("R4 accept timing", vs_first, c0 + 2);

    // R2: vertical edge in the same clock as the horizontal edge
    plain(3);
    n0 = vs_n;
    run_line(0, 8); c0 = hs_drv;
    chk("R2 coincident accepted", vs_n - n0, 1);
    chk("R2 coincident timing", vs_first, c0 + 2);

    // R6: three-line and zero-as-one widths
    tick(1); vs_len = 8'd3;
    plain(4);
    run_line(5, -1);
    run_line(-1, 8); c0 = hs_drv;
    plain(3);
    chk("R6 three-line start", vs_first, c0 + 2);
    chk("R6 three-line width", vs_fall - vs_first, 3 * LINE - 1);
    tick(1); vs_len = 8'd0;
    run_line(5, 8);
    run_line(-1, -1);
    plain(1);
    chk("R6 zero length as one", vs_fall - vs_first, LINE - 1);

    // R7: width follows input
    tick(1); dur_en = 1'b0;
    plain(3);
    run_line(5, -1);
    run_line(-1, -1); c0 = hs_drv;
    run_line(-1, 6);
    plain(1);
    chk("R7 follow start", vs_first, c0 + 2);
    chk("R7 follow end", vs_fall, vs_clr + 2);

    // R5: bypass, no spacing rule
    tick(1); flt_en = 1'b0;
    n0 = vs_n;
    run_line(5, 8);
    chk("R5 bypass start", vs_first, vs_set + 2);
    chk("R5 bypass end", vs_fall, vs_clr + 2);
    run_line(5, 8);
    chk("R5 back-to-back accepted", vs_n - n0, 2);

    // R8: active-low outputs and mixed polarity
    @(posedge clk); hs_pol = 1'b0; vs_pol = 1'b0;
    tick(2);
    chk("R8 hs idle low-pol", int'(hs_out), 1);
    chk("R8 vs idle low-pol", int'(vs_out), 1);
    cnt0 = hs_cnt;
    run_line(5, 8);
    tick(4);
    chk("R8 active-low hs width", hs_cnt - cnt0, 4);
    chk("R8 active-low vs width", vs_fall - vs_first, 3);
    @(posedge clk); hs_pol = 1'b1; vs_pol = 1'b0;
    tick(2);
    chk("R8 mixed hs idle", int'(hs_out), 0);
    chk("R8 mixed vs idle", int'(vs_out), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule